// File: doc/BRIEF.md
# XTS Tweak Sequence Generator

This block produces the per-block tweak values used by XTS-mode encryption or decryption over a batch of consecutive 128-bit cipher blocks. A seed is loaded with a single-cycle strobe. The seed is already the encrypted sector tweak multiplied by alpha^n in GF(2^128), and it is held as a little-endian 128-bit value. The block then emits one tweak per block on a valid/ready stream. The first tweak is the seed itself. Each later tweak is the previous one multiplied by alpha.

The single-step multiply works on two 64-bit lanes. The top bit of the low lane carries into the bottom bit of the high lane. When bit 127 falls off the top, the constant 0x87 is folded back into the low byte.

A second, independent accumulator advances by alpha^2 once for every two accepted tweaks. When the batch completes, this accumulator presents the seed times alpha^BATCH_LEN on a next-tweak output, so a following batch can continue the sequence. During a batch it also cross-checks the single-step chain.

Top module: `xts_tweak_seq`

## Requirements
- R1: While reset is asserted and after its release, `tw_valid_o` and `next_valid_o` are 0.
- R2: One clock after `load_i` is sampled high, `tw_valid_o` is 1, `tw_data_o` equals the loaded seed and `tw_idx_o` is 0.
- R3: Each accepted tweak (`tw_valid_o` and `tw_ready_i` both high at a clock edge) is followed by tweak k+1. Tweak k+1 is tweak k shifted left by one bit, with bit 63 moving into bit 64. When bit 127 of tweak k was 1, 0x87 is XORed into bits 7:0. `tw_idx_o` increments by one.
- R4: The next-tweak value is built by BATCH_LEN/2 double steps. A double step shifts left by two bits and moves bits 63:62 into bits 65:64. It XORs 0x10E into bits 15:0 when the old bit 127 was 1, and 0x87 when the old bit 126 was 1.
- R5: Exactly BATCH_LEN tweaks are offered per batch (indices 0 to BATCH_LEN-1). After the last one is accepted, `tw_valid_o` is 0 and further `tw_ready_i` has no effect.
- R6: While `tw_valid_o` is 1 and `tw_ready_i` is 0, `tw_data_o`, `tw_idx_o` and `tw_valid_o` hold their values.
- R7: `next_valid_o` is 0 during a batch. It rises in the cycle after the last tweak is accepted, with `next_tweak_o` equal to seed times alpha^BATCH_LEN. It stays so until the next load.
- R8: A load during a batch abandons that batch and restarts from the new seed, as in R2.
- R9: Two single steps equal one double step for every value, including values with bit 126 and/or bit 127 set. Therefore `next_tweak_o` always matches BATCH_LEN single steps of the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Load strobe: start a new batch from `seed_i` |
| seed_i | input | 128 | Starting tweak (encrypted tweak times alpha^n) |
| tw_ready_i | input | 1 | Consumer accepts the current tweak |
| tw_valid_o | output | 1 | A tweak is offered |
| tw_data_o | output | 128 | Current tweak |
| tw_idx_o | output | $clog2(BATCH_LEN) | Position of the current tweak in the batch |
| next_valid_o | output | 1 | Batch finished; `next_tweak_o` is final |
| next_tweak_o | output | 128 | Seed times alpha^BATCH_LEN once the batch is finished |

## Verification
The bench builds the block with the default BATCH_LEN of 16. That is one full 16-tweak batch per seed, and it takes eight double steps to reach alpha^16. Every lane carry and every reduction case is therefore reached within a single batch. Seeds with bits 126 and 127 set, a seed with only bit 63 set, all-ones and zero are exercised, together with random seeds and random back-pressure. A mid-batch reload brings the abandon path within reach.

// File: rtl/xts_tweak_pkg.sv
package xts_tweak_pkg;
  localparam int TW_W   = 128;
  localparam int LANE_W = TW_W / 2;
  // reduction polynomial x^7+x^2+x+1 for x^128
  localparam logic [LANE_W-1:0] RED_ONE = LANE_W'(64'h87);
  // x^129 folded: the one-step constant shifted once more
  localparam logic [LANE_W-1:0] RED_TWO = LANE_W'(64'h10E);
  typedef logic [TW_W-1:0]   tweak_t;
  typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/xts_gf_alpha.sv
module xts_gf_alpha
  import xts_tweak_pkg::*;
#(
  parameter int POW = 1
) (
  input  tweak_t a_i,
  output tweak_t y_o
);
  lane_t lo_in, hi_in, lo_out, hi_out;

  assign lo_in = a_i[LANE_W-1:0];
  assign hi_in = a_i[TW_W-1:LANE_W];
  assign y_o   = {hi_out, lo_out};

  generate
    if (POW == 1) begin : g_single
      lane_t red;
      assign red    = {LANE_W{a_i[TW_W-1]}} & RED_ONE;
      assign lo_out = {lo_in[LANE_W-2:0], 1'b0} ^ red;
      assign hi_out = {hi_in[LANE_W-2:0], lo_in[LANE_W-1]};

      // a_r3_single_step: lane form matches full-width shift form
      always_comb begin
        if (!$isunknown(a_i)) begin
          a_r3_single_step: assert (y_o == ((a_i << 1) ^
            (a_i[TW_W-1] ? tweak_t'(RED_ONE) : '0)));
        end
      end
    end else begin : g_double
      lane_t red;
      assign red    = ({LANE_W{a_i[TW_W-1]}} & RED_TWO) ^
                      ({LANE_W{a_i[TW_W-2]}} & RED_ONE);
      assign lo_out = {lo_in[LANE_W-3:0], 2'b00} ^ red;
      assign hi_out = {hi_in[LANE_W-3:0], lo_in[LANE_W-1:LANE_W-2]};

      // a_r4_double_step: lane form matches full-width shift form
      always_comb begin
        if (!$isunknown(a_i)) begin
          a_r4_double_step: assert (y_o == ((a_i << 2) ^
            (a_i[TW_W-1] ? tweak_t'(RED_TWO) : '0) ^
            (a_i[TW_W-2] ? tweak_t'(RED_ONE) : '0)));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xts_batch_ctrl.sv
module xts_batch_ctrl #(
  parameter int BATCH_LEN = 16,
  localparam int IDX_W = $clog2(BATCH_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             adv_o,
  output logic             dbl_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BATCH_LEN - 1);

  logic             valid_q, valid_d, done_q, done_d, fire, is_last;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign fire    = valid_q & ready_i & ~load_i;
  assign is_last = (idx_q == LAST_IDX);
  assign adv_o   = fire & ~is_last;
  assign dbl_o   = fire & idx_q[0];

  always_comb begin
    valid_d = valid_q;
    done_d  = done_q;
    idx_d   = idx_q;
    if (load_i) begin
      valid_d = 1'b1;
      done_d  = 1'b0;
      idx_d   = '0;
    end else if (fire) begin
      if (is_last) begin
        valid_d = 1'b0;
        done_d  = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      done_q  <= done_d;
      idx_q   <= idx_d;
    end
  end

  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign idx_o   = idx_q;

  a_r5_batch_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ready_i && !load_i && is_last) |=> (!valid_q && done_q));
  a_r7_not_done_in_batch: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !done_q);
endmodule

// File: rtl/xts_tweak_seq.sv
module xts_tweak_seq
  import xts_tweak_pkg::*;
#(
  parameter int BATCH_LEN = 16,
  localparam int IDX_W = $clog2(BATCH_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [127:0]     seed_i,
  input  logic             tw_ready_i,
  output logic             tw_valid_o,
  output logic [127:0]     tw_data_o,
  output logic [IDX_W-1:0] tw_idx_o,
  output logic             next_valid_o,
  output logic [127:0]     next_tweak_o
);
  tweak_t cur_q, cur_d, nxt_q, nxt_d, cur_step, nxt_step;
  logic   adv, dbl;

  xts_batch_ctrl #(.BATCH_LEN(BATCH_LEN)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .ready_i (tw_ready_i),
    .valid_o (tw_valid_o),
    .done_o  (next_valid_o),
    .idx_o   (tw_idx_o),
    .adv_o   (adv),
    .dbl_o   (dbl)
  );

  xts_gf_alpha #(.POW(1)) step1_i (.a_i(cur_q), .y_o(cur_step));
  xts_gf_alpha #(.POW(2)) step2_i (.a_i(nxt_q), .y_o(nxt_step));

  always_comb begin
    cur_d = cur_q;
    nxt_d = nxt_q;
    if (load_i) begin
      cur_d = seed_i;
      nxt_d = seed_i;
    end else begin
      if (adv) cur_d = cur_step;
      if (dbl) nxt_d = nxt_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      nxt_q <= '0;
    end else begin
      if (load_i || adv) cur_q <= cur_d;
      if (load_i || dbl) nxt_q <= nxt_d;
    end
  end

  assign tw_data_o    = cur_q;
  assign next_tweak_o = nxt_q;

  a_r2_load_seed: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (tw_valid_o && tw_data_o == $past(seed_i) && tw_idx_o == '0));
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_valid_o && !tw_ready_i && !load_i) |=>
      (tw_valid_o && $stable(tw_data_o) && $stable(tw_idx_o)));
  a_r9_single_double_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && tw_idx_o[0]) |=> (tw_data_o == next_tweak_o));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!tw_valid_o && !next_valid_o));
endmodule

// File: tb/xts_tweak_seq_tb_top.sv
module xts_tweak_seq_tb_top;
  localparam int BL = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i;
  logic [127:0] seed_i;
  logic         tw_ready_i;
  logic         tw_valid_o;
  logic [127:0] tw_data_o;
  logic [3:0]   tw_idx_o;
  logic         next_valid_o;
  logic [127:0] next_tweak_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xts_tweak_seq #(.BATCH_LEN(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i),
    .tw_ready_i(tw_ready_i), .tw_valid_o(tw_valid_o), .tw_data_o(tw_data_o),
    .tw_idx_o(tw_idx_o), .next_valid_o(next_valid_o),
    .next_tweak_o(next_tweak_o)
  );

  function automatic logic [127:0] mul_a(input logic [127:0] x);
    return (x << 1) ^ (x[127] ? 128'h87 : 128'h0);
  endfunction

  function automatic logic [127:0] mul_pow(input logic [127:0] x, input int n);
    logic [127:0] r = x;
    for (int i = 0; i < n; i++) r = mul_a(r);
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // stop_at < BL abandons the batch; pct = ready probability in percent
  task automatic run_batch(input logic [127:0] s, input int stop_at, input int pct);
    logic [127:0] exp;
    int k;
    logic r;
    load_i = 1'b1; seed_i = s;
    @(negedge clk);
    load_i = 1'b0;
    chk("R2 valid after load", 128'(tw_valid_o), 128'd1);
    chk("R2 first tweak is seed", tw_data_o, s);
    chk("R7 next_valid low in batch", 128'(next_valid_o), 128'd0);
    exp = s;
    k = 0;
    while (k < stop_at) begin
      r = (($urandom % 100) < pct);
      tw_ready_i = r;
      chk(r ? "R3 tweak value" : "R6 held tweak", tw_data_o, exp);
      chk("R3 index", 128'(tw_idx_o), 128'(k));
      chk("R6 valid held", 128'(tw_valid_o), 128'd1);
      if (r) begin
        k++;
        exp = mul_a(exp);
      end
      @(negedge clk);
    end
    tw_ready_i = 1'b0;
    if (stop_at == BL) begin
      chk("R5 valid drops after last", 128'(tw_valid_o), 128'd0);
      chk("R7 next_valid set", 128'(next_valid_o), 128'd1);
      chk("R4 R9 next tweak = seed*alpha^16", next_tweak_o, mul_pow(s, BL));
      tw_ready_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      tw_ready_i = 1'b0;
      chk("R5 ready ignored after batch", 128'(tw_valid_o), 128'd0);
      chk("R7 next tweak retained", next_tweak_o, mul_pow(s, BL));
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; load_i = 1'b0; seed_i = '0; tw_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 128'(tw_valid_o), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 128'(tw_valid_o), 128'd0);
    chk("R1 next_valid after reset", 128'(next_valid_o), 128'd0);

    // directed corners: bits 126/127 (R9), lane carry (R3), extremes
    run_batch(128'hC000_0000_0000_0000_0000_0000_0000_0001, BL, 100);
    run_batch(128'h8000_0000_0000_0000_0000_0000_0000_0000, BL, 100);
    run_batch(128'h4000_0000_0000_0000_0000_0000_0000_0000, BL, 60);
    run_batch(128'h0000_0000_0000_0000_8000_0000_0000_0000, BL, 70);
    run_batch({128{1'b1}}, BL, 50);
    run_batch(128'h0, BL, 80);
    // R8: abandon mid-batch, then restart
    run_batch(rnd128(), 5, 100);
    run_batch(128'hC3A5_0000_1111_2222_FFFF_0000_8000_0001, BL, 40);
    for (int n = 0; n < 40; n++) begin
      run_batch(rnd128(), (n % 7 == 3) ? int'($urandom % BL) : BL, 30 + int'($urandom % 71));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule